// File: doc/BRIEF.md
# Hybrid Karatsuba Multiplier over a Binary Trinomial Field

This block multiplies two elements of the binary field GF(2^M). Each element is an M-bit polynomial with coefficients in GF(2), and the result is their product reduced modulo the irreducible trinomial x^M + x^K + 1. The block builds the unreduced 2M-1-bit product as a tree that is elaborated recursively. At each level above a threshold width, the operands are cut into a low half of ceiling width and a high half of floor width. Three half-size products are formed: low times low, high times high, and the XOR-sum of the halves times the XOR-sum of the halves. These are combined with XORs. When a sub-multiplier's width is at or below the threshold `LEAF_W`, it uses a direct AND-XOR schoolbook array instead of splitting again.

A single reduction layer folds the wide product back into M bits. It does so by repeatedly mapping each coefficient at degree i ≥ M onto degrees i-M and i-M+K. The field product is either taken straight from this logic or captured in an output register. The register is selected by `REG_OUT` and has a synchronous active-low reset. The defaults are M=233, K=74 and LEAF_W=16.

Top module: `gf2m_kara_mul`

## Requirements
- R1: `prod` equals `opa`·`opb` mod (x^M + x^K + 1), where bit i of each bus is the coefficient of x^i.
- R2: With `REG_OUT`=1, the product of the operands present at a rising clock edge appears on `prod` after that edge and holds until the next edge.
- R3: While `rst_n` is low at a rising edge, the registered `prod` is cleared to all zeros at that edge.
- R4: If either operand is zero, the product is zero.
- R5: If either operand is the field one (only bit 0 set), the product equals the other operand.
- R6: The multiplication is commutative: swapping `opa` and `opb` gives the same `prod`.
- R7: A single overflow term folds to the trinomial's low terms: x^(M-1) · x = x^K + 1, so only bits K and 0 of `prod` are set.
- R8: Top-degree terms are fully reduced: x^(M-1) · x^(M-1), and all-ones times all-ones, match the reference field product, with no coefficient left at or above degree M.
- R9: Operand widths that are odd at any level split into a ceiling low half and a floor high half. A small configuration (M=7, K=1, LEAF_W=2), which recurses down to widths of 1 and 2, gives correct field products for every tested operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| opa | input | M | First field operand, bit i is the coefficient of x^i |
| opb | input | M | Second field operand |
| prod | output | M | Reduced field product |

## Verification
In the default configuration the output register is present, so every product is due one rising edge after its operands were set up. The bench drives operands on the falling edge and reads `prod` on the following falling edge, which lies after exactly one rising edge. In this way each check sees the result of the operands it just applied and never a stale or half-updated value. The reset check applies the operand values while `rst_n` is still low and expects zero after that same edge. It then releases reset and expects the real product one edge later.

// File: rtl/gf_kara_pkg.sv
// Package gf_kara_pkg
// Width helpers shared by the hybrid Karatsuba multiplier tree and the
// trinomial reduction stage. Assumes all widths are positive.
package gf_kara_pkg;

    // Width of an unreduced product of two w-bit binary polynomials.
    function automatic int prod_w(input int w);
        return 2 * w - 1;
    endfunction

    // Low (ceiling) half used when a w-bit operand is split.
    function automatic int lo_half(input int w);
        return (w + 1) / 2;
    endfunction

    // High (floor) half used when a w-bit operand is split.
    function automatic int hi_half(input int w);
        return w / 2;
    endfunction

endpackage

// File: rtl/kara_school_mul.sv
// Module kara_school_mul
// Direct AND-XOR (schoolbook) carry-less multiplier of two W-bit binary
// polynomials, giving the full 2W-1-bit product. Purely combinational.
// Assumes W >= 1. Used as the leaf of the Karatsuba tree.
module kara_school_mul
    import gf_kara_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]            a,
    input  logic [W-1:0]            b,
    output logic [prod_w(W)-1:0]    p
);

    localparam int PW = prod_w(W);

    // Accumulate every partial product a[i]&b[j] into coefficient i+j.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
                p[i+j] = p[i+j] ^ (a[i] & b[j]);
            end
        end
    end

    // Keep PW referenced for readers checking the output width.
    if (PW != 2 * W - 1) begin : g_bad_width
        $error("kara_school_mul: product width mismatch");
    end

endmodule

// File: rtl/kara_tree_mul.sv
// Module kara_tree_mul
// Recursive hybrid multiplier of two W-bit binary polynomials producing the
// unreduced 2W-1-bit product. Widths at or below LEAF_W use the schoolbook
// array. Wider operands are split into a ceiling-width low half and a
// floor-width high half, and three sub-products are formed:
//   ll = Al*Bl, hh = Ah*Bh, mm = (Al^Ah)*(Bl^Bh)
// which combine as ll ^ ((mm^ll^hh) << H) ^ (hh << 2H).
// Assumes W >= 1 and LEAF_W >= 1. Purely combinational.
module kara_tree_mul
    import gf_kara_pkg::*;
#(
    parameter int W      = 16,
    parameter int LEAF_W = 4
) (
    input  logic [W-1:0]            a,
    input  logic [W-1:0]            b,
    output logic [prod_w(W)-1:0]    p
);

    localparam int PW = prod_w(W);

    if (W <= LEAF_W || W < 2) begin : g_leaf
        // Threshold reached: no further splitting.
        kara_school_mul #(.W(W)) u_school (
            .a (a),
            .b (b),
            .p (p)
        );
    end else begin : g_split
        localparam int H   = lo_half(W);
        localparam int L   = hi_half(W);
        localparam int PH  = prod_w(H);
        localparam int PL  = prod_w(L);

        logic [H-1:0]  a_lo, b_lo, a_sum, b_sum;
        logic [L-1:0]  a_hi, b_hi;
        logic [PH-1:0] p_ll, p_mm;
        logic [PL-1:0] p_hh;
        logic [PH-1:0] hh_in_h;
        logic [PH-1:0] mid;
        logic [PW-1:0] ll_x, mid_x, hh_x;

        // Split operands and form the half sums for the middle product.
        always_comb begin
            a_lo  = a[H-1:0];
            b_lo  = b[H-1:0];
            a_hi  = a[W-1:H];
            b_hi  = b[W-1:H];
            a_sum = a_lo;
            b_sum = b_lo;
            a_sum[L-1:0] = a_lo[L-1:0] ^ a_hi;
            b_sum[L-1:0] = b_lo[L-1:0] ^ b_hi;
        end

        kara_tree_mul #(.W(H), .LEAF_W(LEAF_W)) u_ll (
            .a (a_lo),
            .b (b_lo),
            .p (p_ll)
        );

        kara_tree_mul #(.W(L), .LEAF_W(LEAF_W)) u_hh (
            .a (a_hi),
            .b (b_hi),
            .p (p_hh)
        );

        kara_tree_mul #(.W(H), .LEAF_W(LEAF_W)) u_mm (
            .a (a_sum),
            .b (b_sum),
            .p (p_mm)
        );

        // Combine the three sub-products into the full-width product.
        always_comb begin
            hh_in_h             = '0;
            hh_in_h[PL-1:0]     = p_hh;
            mid                 = p_mm ^ p_ll ^ hh_in_h;
            ll_x                = '0;
            ll_x[PH-1:0]        = p_ll;
            mid_x               = '0;
            mid_x[PH-1:0]       = mid;
            mid_x               = mid_x << H;
            hh_x                = '0;
            hh_x[PW-1:2*H]      = p_hh;
            p                   = ll_x ^ mid_x ^ hh_x;
        end
    end

endmodule

// File: rtl/kara_trinomial_reduce.sv
// Module kara_trinomial_reduce
// Reduces a 2M-1-bit binary polynomial modulo x^M + x^K + 1 to M bits.
// Coefficients are folded from the highest degree downward: a set bit at
// degree i >= M is cleared and XORed into degrees i-M and i-M+K. Since
// i-M+K < i, folded bits are revisited by later iterations if they still
// lie at or above M. Assumes 0 < K < M. Purely combinational.
module kara_trinomial_reduce
    import gf_kara_pkg::*;
#(
    parameter int M = 233,
    parameter int K = 74
) (
    input  logic [prod_w(M)-1:0] wide,
    output logic [M-1:0]         red
);

    localparam int PW = prod_w(M);

    // Fold every coefficient at or above degree M into the low part.
    always_comb begin
        logic [PW-1:0] t;
        t = wide;
        for (int i = PW - 1; i >= M; i--) begin
            t[i-M]   = t[i-M]   ^ t[i];
            t[i-M+K] = t[i-M+K] ^ t[i];
            t[i]     = 1'b0;
        end
        red = t[M-1:0];
    end

endmodule

// File: rtl/gf2m_kara_mul.sv
// Module gf2m_kara_mul
// Field multiplier for GF(2^M) defined by the trinomial x^M + x^K + 1.
// A recursive hybrid Karatsuba/schoolbook tree forms the unreduced product,
// a single fold layer reduces it, and an optional output register
// (REG_OUT=1) with synchronous active-low reset presents the result.
// Assumes 0 < K < M and that the trinomial is irreducible for field use.
module gf2m_kara_mul
    import gf_kara_pkg::*;
#(
    parameter int M       = 233,
    parameter int K       = 74,
    parameter int LEAF_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] opa,
    input  logic [M-1:0] opb,
    output logic [M-1:0] prod
);

    localparam int PW = prod_w(M);

    logic [PW-1:0] full_prod;
    logic [M-1:0]  field_prod;

    kara_tree_mul #(.W(M), .LEAF_W(LEAF_W)) u_tree (
        .a (opa),
        .b (opb),
        .p (full_prod)
    );

    kara_trinomial_reduce #(.M(M), .K(K)) u_reduce (
        .wide (full_prod),
        .red  (field_prod)
    );

    if (REG_OUT) begin : g_reg
        logic [M-1:0] prod_q;
        // Capture the reduced product; clear on synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= field_prod;
        end
        assign prod = prod_q;
    end else begin : g_comb
        assign prod = field_prod;
    end

endmodule

// File: rtl/gf2m_kara_mul_chk.sv
// Module gf2m_kara_mul_chk
// Property checker bound to every gf2m_kara_mul instance. It checks the
// algebraic identities that can be stated over the ports with the output
// latency set by REG_OUT.
module gf2m_kara_mul_chk #(
    parameter int M       = 233,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [M-1:0] opa,
    input logic [M-1:0] opb,
    input logic [M-1:0] prod
);

    localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

    if (REG_OUT) begin : g_seq
        // R3
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> prod == '0);
        // R4
        zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opa == '0 |=> prod == '0);
        // R4
        zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opb == '0 |=> prod == '0);
        // R5
        one_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opa == ONE |=> prod == $past(opb));
        // R5
        one_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opb == ONE |=> prod == $past(opa));
    end else begin : g_comb
        // R4
        zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opa == '0 |-> prod == '0);
        // R5
        one_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opa == ONE |-> prod == opb);
        // R5
        one_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opb == ONE |-> prod == opa);
        // R4
        zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            opb == '0 |-> prod == '0);
    end

endmodule

bind gf2m_kara_mul gf2m_kara_mul_chk #(.M(M), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .opa   (opa),
    .opb   (opb),
    .prod  (prod)
);

// File: tb/gf2m_kara_mul_test.sv
// Directed bench for gf2m_kara_mul: default field (M=233, K=74) as uut and a
// small field (M=7, K=1, LEAF_W=2) as uut_small, compared against a
// bit-serial shift-and-add reference with reduction.
module gf2m_kara_mul_test;

    localparam int M  = 233;
    localparam int K  = 74;
    localparam int SM = 7;
    localparam int SK = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [M-1:0]  opa = '0, opb = '0, prod;
    logic [SM-1:0] sa = '0, sb = '0, sprod;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gf2m_kara_mul #(.M(M), .K(K), .LEAF_W(16), .REG_OUT(1'b1)) uut (
        .clk (clk), .rst_n (rst_n), .opa (opa), .opb (opb), .prod (prod)
    );

    gf2m_kara_mul #(.M(SM), .K(SK), .LEAF_W(2), .REG_OUT(1'b1)) uut_small (
        .clk (clk), .rst_n (rst_n), .opa (sa), .opb (sb), .prod (sprod)
    );

    // Reference: bit-serial shift-and-add multiply modulo x^m + x^k + 1.
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a,
                                             input logic [M-1:0] b,
                                             input int m, input int k);
        logic [M:0] acc, sh;
        acc = '0;
        sh  = '0;
        sh[M-1:0] = a;
        for (int i = 0; i < m; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh << 1;
            if (sh[m]) begin
                sh[m] = 1'b0;
                sh[k] = ~sh[k];
                sh[0] = ~sh[0];
            end
        end
        return acc[M-1:0];
    endfunction

    function automatic logic [M-1:0] rand_op();
        logic [M-1:0] v;
        v = '0;
        for (int i = 0; i < 8; i++) v = (v << 32) | M'($urandom);
        return v;
    endfunction

    task automatic check(input string req, input logic [M-1:0] act,
                         input logic [M-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on falling edge, read after exactly one rising edge.
    task automatic apply(input logic [M-1:0] a, input logic [M-1:0] b);
        @(negedge clk);
        opa = a;
        opb = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        opa = rand_op();
        opb = rand_op() | 1;
        @(negedge clk);
        check("R3 reset clears prod", prod, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 product one edge after release", prod, ref_mul(opa, opb, M, K));
    endtask

    task automatic t_zero();
        logic [M-1:0] r;
        r = rand_op();
        apply('0, r);
        check("R4 zero times operand", prod, '0);
        apply(r, '0);
        check("R4 operand times zero", prod, '0);
    endtask

    task automatic t_one();
        logic [M-1:0] r;
        r = rand_op();
        apply(M'(1), r);
        check("R5 one times operand", prod, r);
        apply(r, M'(1));
        check("R5 operand times one", prod, r);
    endtask

    task automatic t_fold();
        logic [M-1:0] top, exp;
        top = '0;
        top[M-1] = 1'b1;
        exp = '0;
        exp[K] = 1'b1;
        exp[0] = 1'b1;
        apply(top, M'(2));
        check("R7 x^(M-1)*x folds to x^K+1", prod, exp);
        apply(top, top);
        check("R8 top term squared", prod, ref_mul(top, top, M, K));
        apply('1, '1);
        check("R8 all-ones squared", prod, ref_mul('1, '1, M, K));
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            logic [M-1:0] a, b;
            a = rand_op();
            b = rand_op();
            apply(a, b);
            check("R1 random product", prod, ref_mul(a, b, M, K));
            apply(b, a);
            check("R6 swapped operands", prod, ref_mul(a, b, M, K));
        end
    endtask

    task automatic t_hold();
        logic [M-1:0] a, b;
        a = rand_op();
        b = rand_op();
        apply(a, b);
        @(posedge clk);
        #1;
        check("R2 prod holds between edges", prod, ref_mul(a, b, M, K));
    endtask

    task automatic t_small();
        for (int x = 0; x < 128; x += 3) begin
            for (int y = 0; y < 128; y += 5) begin
                @(negedge clk);
                sa = SM'(x);
                sb = SM'(y);
                @(negedge clk);
                check("R9 small field odd split",
                      M'(sprod), ref_mul(M'(x), M'(y), SM, SK));
            end
        end
    endtask

    initial begin
        t_reset();
        t_zero();
        t_one();
        t_fold();
        t_random();
        t_hold();
        t_small();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule